// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a programmable countdown watchdog with a small word-addressed register file. A prescaler turns the system clock into timer ticks, and each tick lowers a 10-bit count. Software keeps the system alive by writing the count register, which reloads the count from the programmed initial value. The count runs only while the halt bit is clear.

When the count expires for the first time, a write-1-to-clear timeout flag is set. An interrupt request follows that flag while its enable bit is set. The count then reloads and runs again. If it expires a second time while the first flag is still set, a second-timeout flag is recorded and a one-cycle system reset request is issued, unless the no-reboot bit is set. The bus bridge in front of the block and the reset sequencing after the request are outside it.

The register map uses word addresses: 0 is the count (a write of any data reloads, a read returns the live count), 1 is the initial value, 2 is timeout status, 3 is second-timeout status, 4 is control, 5 is interrupt enable and 6 is the no-reboot control. Address 7 reads zero.

Top module: `wdt_dual_stage`

## Requirements
- R1: After reset the timer is halted (address 4 reads 0x0800), the initial value and the count are both DEFAULT_INIT (50), both status registers read 0, interrupt enable reads 0, no-reboot (address 6) reads 0x0001, and smi_req and rst_req are low.
- R2: A write to address 1 changes only bits [9:0] of the initial value. Bits [15:10] of address 1 always read 0.
- R3: A write to address 1 with a value below MIN_INIT (4) in bits [9:0] is ignored, and the earlier initial value is kept. The value 4 itself is accepted.
- R4: Any write to address 0 loads the count from the initial value and restarts the prescaler, whatever the write data. A change of the initial value alone does not change the count.
- R5: While bit 11 of address 4 is 1, the count and the prescaler are frozen. After the bit is cleared, the first decrement comes a full TICK_DIV cycles later.
- R6: While running, the count drops by one every TICK_DIV clock cycles. Address 0 returns the live count in bits [9:0].
- R7: A tick that arrives while the count is 0 is an expiry: the count reloads from the initial value and bit 3 of address 2 becomes 1. With initial value N, the first expiry comes (N+1)*TICK_DIV cycles after the timer starts.
- R8: smi_req is high exactly while bit 3 of address 2 and bit 13 of address 5 are both 1.
- R9: Bit 3 of address 2 and bit 1 of address 3 are cleared only by writing 1 to that bit. Writing 0, or writing to other bits, leaves them unchanged. A hardware set in the same cycle wins over a clear.
- R10: An expiry while bit 3 of address 2 is 1 sets bit 1 of address 3. If the no-reboot bit is 0, it also drives rst_req high for exactly the one cycle after that clock edge.
- R11: While bit 0 of address 6 is 1, rst_req stays low on a second expiry, but bit 1 of address 3 is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | 3 | Word address for both read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| smi_req | output | 1 | First-stage interrupt request level |
| rst_req | output | 1 | One-cycle system reset request pulse |

## Verification
The bench targets the exact expiry cycle and the one before it. A design that counted expiry on reaching zero, rather than on the tick after zero, would set the status one tick early. It tries initial values of 3, 0 and 4 and a write with the upper bits set. A design that took an illegal value would later expire after only one to four ticks, and one that stored the upper bits would read them back. It stops the timer in the middle of a count to show that a leaky halt shows up as a lost count. It drives the second expiry with the no-reboot bit both clear and set, checking the pulse width and that the status is recorded when the pulse is blocked. It also checks that writes of 0 to the status bits clear nothing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [2:0] {
      WA_COUNT = 3'd0,
      WA_INIT  = 3'd1,
      WA_STS1  = 3'd2,
      WA_STS2  = 3'd3,
      WA_CTRL  = 3'd4,
      WA_SMIEN = 3'd5,
      WA_NORB  = 3'd6
   } wdt_addr_e;

   localparam int REG_W     = 16;
   localparam int ADDR_W    = 3;
   localparam int HALT_BIT  = 11;
   localparam int TO_BIT    = 3;
   localparam int TO2_BIT   = 1;
   localparam int SMIEN_BIT = 13;
   localparam int NORB_BIT  = 0;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int unsigned TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   if (TICK_DIV < 1) begin : g_bad_div
      $error("wdt_tick_gen: TICK_DIV must be at least 1");
   end

   if (TICK_DIV == 1) begin : g_bypass
      logic unused_bypass;
      assign unused_bypass = clk ^ rst_n;
      assign tick = run && !restart;
   end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
         end else if (!run || restart) begin
            pre_q <= '0;
         end else if (pre_q == LAST) begin
            pre_q <= '0;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end

      assign tick = run && !restart && (pre_q == LAST);
   end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int CNT_W        = 10,
   parameter int DEFAULT_INIT = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] init_val,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   logic [CNT_W-1:0] count_q;

   assign expire = tick && !load && (count_q == '0);
   assign count  = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= CNT_W'(DEFAULT_INIT);
      end else if (load || expire) begin
         count_q <= init_val;
      end else if (tick) begin
         count_q <= count_q - 1'b1;
      end
   end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int CNT_W        = 10,
   parameter int DEFAULT_INIT = 50,
   parameter int MIN_INIT     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              expire,
   output logic [CNT_W-1:0]  init_val,
   output logic              halt,
   output logic              reload_wr,
   output logic              sts1,
   output logic              sts2,
   output logic              noreboot,
   output logic              smi_req,
   output logic              rst_req
);
   logic wr_init, wr_sts1, wr_sts2, wr_ctrl, wr_smien, wr_norb;
   logic [CNT_W-1:0] init_q;
   logic halt_q, sts1_q, sts2_q, smien_q, norb_q, rst_q;
   logic unused_wbits;

   assign unused_wbits = ^wdata;

   assign reload_wr = wr_en && (addr == WA_COUNT);
   assign wr_init   = wr_en && (addr == WA_INIT);
   assign wr_sts1   = wr_en && (addr == WA_STS1);
   assign wr_sts2   = wr_en && (addr == WA_STS2);
   assign wr_ctrl   = wr_en && (addr == WA_CTRL);
   assign wr_smien  = wr_en && (addr == WA_SMIEN);
   assign wr_norb   = wr_en && (addr == WA_NORB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= CNT_W'(DEFAULT_INIT);
      end else if (wr_init && (wdata[CNT_W-1:0] >= CNT_W'(MIN_INIT))) begin
         init_q <= wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q  <= 1'b1;
         smien_q <= 1'b0;
         norb_q  <= 1'b1;
      end else begin
         if (wr_ctrl)  halt_q  <= wdata[HALT_BIT];
         if (wr_smien) smien_q <= wdata[SMIEN_BIT];
         if (wr_norb)  norb_q  <= wdata[NORB_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts1_q <= 1'b0;
         sts2_q <= 1'b0;
         rst_q  <= 1'b0;
      end else begin
         if (expire) begin
            sts1_q <= 1'b1;
         end else if (wr_sts1 && wdata[TO_BIT]) begin
            sts1_q <= 1'b0;
         end
         if (expire && sts1_q) begin
            sts2_q <= 1'b1;
         end else if (wr_sts2 && wdata[TO2_BIT]) begin
            sts2_q <= 1'b0;
         end
         rst_q <= expire && sts1_q && !norb_q;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         WA_COUNT: rdata[CNT_W-1:0]  = count;
         WA_INIT:  rdata[CNT_W-1:0]  = init_q;
         WA_STS1:  rdata[TO_BIT]     = sts1_q;
         WA_STS2:  rdata[TO2_BIT]    = sts2_q;
         WA_CTRL:  rdata[HALT_BIT]   = halt_q;
         WA_SMIEN: rdata[SMIEN_BIT]  = smien_q;
         WA_NORB:  rdata[NORB_BIT]   = norb_q;
         default:  rdata = '0;
      endcase
   end

   assign init_val = init_q;
   assign halt     = halt_q;
   assign sts1     = sts1_q;
   assign sts2     = sts2_q;
   assign noreboot = norb_q;
   assign smi_req  = sts1_q && smien_q;
   assign rst_req  = rst_q;
endmodule

// File: rtl/wdt_dual_stage.sv
module wdt_dual_stage
   import wdt_pkg::*;
#(
   parameter int unsigned TICK_DIV     = 60_000_000,
   parameter int          CNT_W        = 10,
   parameter int          DEFAULT_INIT = 50,
   parameter int          MIN_INIT     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              smi_req,
   output logic              rst_req
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (CNT_W < 3 || CNT_W > REG_W) begin : g_bad_width
      $error("wdt_dual_stage: CNT_W out of range");
   end
   if (MIN_INIT < 1 || DEFAULT_INIT < MIN_INIT || DEFAULT_INIT > CNT_MAX) begin : g_bad_init
      $error("wdt_dual_stage: DEFAULT_INIT outside the legal reload range");
   end

   logic             tick_w, expire_w, halt_w, reload_w;
   logic             sts1_w, sts2_w, noreboot_w;
   logic [CNT_W-1:0] count_w, init_w;

   wdt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (!halt_w),
      .restart (reload_w),
      .tick    (tick_w)
   );

   wdt_countdown #(.CNT_W(CNT_W), .DEFAULT_INIT(DEFAULT_INIT)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_w),
      .load     (reload_w),
      .init_val (init_w),
      .count    (count_w),
      .expire   (expire_w)
   );

   wdt_regs #(.CNT_W(CNT_W), .DEFAULT_INIT(DEFAULT_INIT), .MIN_INIT(MIN_INIT)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .count     (count_w),
      .expire    (expire_w),
      .init_val  (init_w),
      .halt      (halt_w),
      .reload_wr (reload_w),
      .sts1      (sts1_w),
      .sts2      (sts2_w),
      .noreboot  (noreboot_w),
      .smi_req   (smi_req),
      .rst_req   (rst_req)
   );
endmodule

// File: rtl/wdt_dual_stage_chk.sv
module wdt_dual_stage_chk #(
   parameter int CNT_W    = 10,
   parameter int MIN_INIT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rst_req,
   input logic             expire,
   input logic             reload,
   input logic             halt,
   input logic             sts1,
   input logic             sts2,
   input logic             noreboot,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] init_val
);
   // R10: the reset request is a single-cycle pulse
   p_rst_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R10: a reset request follows an expiry seen with the first flag set
   p_rst_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ($past(expire) && $past(sts1)));

   // R11: no reset request while no-reboot was set
   p_rst_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> !$past(noreboot));

   // R5: a halted timer does not move unless reloaded
   p_halt_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !reload) |=> $stable(count));

   // R6: any change not caused by a reload or expiry is a single decrement
   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reload) && !$past(expire) && (count != $past(count)))
         |-> (count == CNT_W'($past(count) - 1'b1)));

   // R9: second-timeout flag rises only with the first flag already set
   p_sts2_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts2) |-> $past(sts1));

   // R3: the stored initial value never falls below the legal minimum
   p_init_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      init_val >= CNT_W'(MIN_INIT));
endmodule

bind wdt_dual_stage wdt_dual_stage_chk #(.CNT_W(CNT_W), .MIN_INIT(MIN_INIT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rst_req  (rst_req),
   .expire   (expire_w),
   .reload   (reload_w),
   .halt     (halt_w),
   .sts1     (sts1_w),
   .sts2     (sts2_w),
   .noreboot (noreboot_w),
   .count    (count_w),
   .init_val (init_w)
);

// File: tb/wdt_dual_stage_tb.sv
`timescale 1ns/1ps
module wdt_dual_stage_tb;
   localparam int TDIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic        smi_req, rst_req;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wdt_dual_stage #(.TICK_DIV(TDIV), .CNT_W(10), .DEFAULT_INIT(50), .MIN_INIT(4)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .smi_req   (smi_req),
      .rst_req   (rst_req)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      rd(3'd0, 16'h0032, "R1 count");
      rd(3'd1, 16'h0032, "R1 init");
      rd(3'd4, 16'h0800, "R1 halt");
      rd(3'd2, 16'h0000, "R1 sts1");
      rd(3'd3, 16'h0000, "R1 sts2");
      rd(3'd5, 16'h0000, "R1 smi enable");
      rd(3'd6, 16'h0001, "R1 no-reboot");
      rd(3'd7, 16'h0000, "R1 unused address");
      chk("R1 smi_req", {15'd0, smi_req}, 16'h0);
      chk("R1 rst_req", {15'd0, rst_req}, 16'h0);
   endtask

   task automatic t_init_field;
      wr(3'd1, 16'hFC07);
      rd(3'd1, 16'h0007, "R2 upper bits dropped");
      wr(3'd1, 16'h0003);
      rd(3'd1, 16'h0007, "R3 value 3 ignored");
      wr(3'd1, 16'h0000);
      rd(3'd1, 16'h0007, "R3 value 0 ignored");
      wr(3'd1, 16'h0004);
      rd(3'd1, 16'h0004, "R3 value 4 accepted");
      wr(3'd1, 16'h03FF);
      rd(3'd1, 16'h03FF, "R2 full field");
   endtask

   task automatic t_reload_halt;
      rd(3'd0, 16'h0032, "R4 init change alone keeps count");
      wr(3'd1, 16'h0008);
      wr(3'd0, 16'hABCD);
      rd(3'd0, 16'h0008, "R4 reload on any write");
      wr(3'd4, 16'h0000);
      step(6);
      rd(3'd0, 16'h0007, "R6 one decrement per TICK_DIV");
      wr(3'd4, 16'h0800);
      step(20);
      rd(3'd0, 16'h0007, "R5 frozen while halted");
      wr(3'd4, 16'h0000);
      step(3);
      rd(3'd0, 16'h0007, "R5 prescaler restarted");
      step(1);
      rd(3'd0, 16'h0006, "R6 decrement after resume");
      wr(3'd4, 16'h0800);
      wr(3'd1, 16'h0004);
   endtask

   task automatic t_two_stage_reboot;
      wr(3'd6, 16'h0000);
      wr(3'd5, 16'h0000);
      wr(3'd0, 16'h0000);
      wr(3'd4, 16'h0000);
      step(19);
      rd(3'd2, 16'h0000, "R7 no expiry one cycle early");
      rd(3'd0, 16'h0000, "R7 count at zero");
      step(1);
      rd(3'd2, 16'h0008, "R7 first expiry flag");
      rd(3'd0, 16'h0004, "R7 reload after expiry");
      chk("R8 smi gated off", {15'd0, smi_req}, 16'h0);
      chk("R10 no reset at first expiry", {15'd0, rst_req}, 16'h0);
      wr(3'd5, 16'h2000);
      chk("R8 smi level with enable", {15'd0, smi_req}, 16'h1);
      step(18);
      chk("R10 no reset early", {15'd0, rst_req}, 16'h0);
      rd(3'd3, 16'h0000, "R10 sts2 not yet");
      step(1);
      chk("R10 reset pulse", {15'd0, rst_req}, 16'h1);
      rd(3'd3, 16'h0002, "R10 sts2 set");
      rd(3'd2, 16'h0008, "R10 sts1 held");
      step(1);
      chk("R10 pulse one cycle", {15'd0, rst_req}, 16'h0);
      wr(3'd4, 16'h0800);
      wr(3'd2, 16'h0000);
      rd(3'd2, 16'h0008, "R9 write 0 keeps sts1");
      wr(3'd2, 16'hFFF7);
      rd(3'd2, 16'h0008, "R9 other bits keep sts1");
      wr(3'd2, 16'h0008);
      rd(3'd2, 16'h0000, "R9 W1C sts1");
      chk("R8 smi drops with flag", {15'd0, smi_req}, 16'h0);
      wr(3'd3, 16'h0000);
      rd(3'd3, 16'h0002, "R9 write 0 keeps sts2");
      wr(3'd3, 16'h0002);
      rd(3'd3, 16'h0000, "R9 W1C sts2");
   endtask

   task automatic t_two_stage_blocked;
      int highs = 0;
      wr(3'd6, 16'h0001);
      wr(3'd5, 16'h0000);
      wr(3'd0, 16'h0000);
      wr(3'd4, 16'h0000);
      for (int i = 0; i < 40; i++) begin
         step(1);
         if (rst_req) highs++;
      end
      chk("R11 reset suppressed", 16'(highs), 16'h0);
      rd(3'd3, 16'h0002, "R11 sts2 still recorded");
      rd(3'd2, 16'h0008, "R11 sts1 set");
      chk("R8 smi off without enable", {15'd0, smi_req}, 16'h0);
      wr(3'd4, 16'h0800);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_init_field();
      t_reload_halt();
      t_two_stage_reboot();
      t_two_stage_blocked();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired before the bench finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule